// File: doc/BRIEF.md
# Single-Error-Correcting Memory Word Encoder and Checker

This block sits between a memory array and its users and guards each 8-bit data word with a Hamming code. On the write side it turns the data byte into a 12-bit codeword: four check bits at the power-of-two positions and the eight data bits spread over the remaining positions. A thirteenth bit of even parity over the whole word can be added for double-error detection. The encoded word goes to the storage array, which is not part of this block.

On the read side the codeword coming back from storage is checked. The check bits are recomputed and combined with the stored ones into a 4-bit syndrome. A single flipped bit is located and flipped back. The corrected data goes out, together with the fully repaired codeword and a write-back request, so that the same location can be rewritten. Patterns that no single flip can explain are flagged as uncorrectable and left unmodified. Both paths go through one optional output register, so a write and a read can be handled in the same cycle.

Top module: `hamm_secded`

## Requirements
- R1: `wr_code_o` carries the encoded `wr_data_i`. Codeword position k (1 to 12) is bit k-1. Data bit i sits, in rising order, at positions 3, 5, 6, 7, 9, 10, 11 and 12. The check bit at position 1 is the XOR of positions 3, 5, 7, 9 and 11. Position 2 is the XOR of 3, 6, 7, 10 and 11. Position 4 is the XOR of 5, 6, 7 and 12. Position 8 is the XOR of 9, 10, 11 and 12. Bit 12 (position 13) makes the XOR of all 13 bits zero.
- R2: A read codeword with no flipped bit yields its data bits on `rd_data_o`, returns itself on `fix_code_o`, and raises no flag.
- R3: A read codeword with exactly one flipped data position yields the original data byte and raises `err_single_o`.
- R4: A single flip of a check position (1, 2, 4 or 8) leaves `rd_data_o` equal to the original data and raises `err_single_o`.
- R5: Whenever a single error is corrected during a valid read, `wb_req_o` is high for that result cycle and `fix_code_o` equals the clean encoding of the original data.
- R6: A nonzero syndrome with even overall parity (two flips) raises `err_double_o` only. No bit is corrected: `fix_code_o` equals the received word, `rd_data_o` is its raw data positions, and `wb_req_o` stays low.
- R7: A syndrome of 13, 14 or 15 is reported on `err_double_o` without correction, whatever the overall parity.
- R8: A flip of only the overall-parity bit (position 13) raises `err_single_o` and `wb_req_o`, leaves the data intact, and `fix_code_o` restores that bit.
- R9: While `rd_valid_i` is low, `err_single_o`, `err_double_o` and `wb_req_o` stay low whatever the read codeword. `rd_data_o` and `fix_code_o` still show the checker's result.
- R10: With the output register present (default), every output reflects the inputs of the previous clock edge. Reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_data_i | input | 8 | Data byte to encode |
| wr_code_o | output | 13 | Encoded codeword to storage |
| rd_valid_i | input | 1 | Read codeword is valid this cycle |
| rd_code_i | input | 13 | Codeword read from storage |
| rd_data_o | output | 8 | Corrected read data |
| fix_code_o | output | 13 | Corrected codeword for write-back |
| err_single_o | output | 1 | Single error found and corrected |
| err_double_o | output | 1 | Uncorrectable error found |
| wb_req_o | output | 1 | Request to rewrite the corrected word |

## Verification
Encoding a new write and checking a read can fall in the same cycle, because they share the output register. Every stimulus in the bench therefore drives a fresh write byte and a (possibly corrupted) read codeword together. The scoreboard compares the encoded word and the corrected read against values built from the position equations in R1. A fault in either path, or any crossing between them, shows up as a mismatch on the other field of the same result.

// File: rtl/hamm_pkg.sv
package hamm_pkg;

    typedef enum logic [1:0] {
        ECC_CLEAN = 2'd0,
        ECC_FIXED = 2'd1,
        ECC_FATAL = 2'd2
    } ecc_class_e;

    // number of check bits needed for a given data width
    function automatic int chk_bits(input int dw);
        int c;
        c = 1;
        while ((1 << c) < dw + c + 1) c++;
        return c;
    endfunction

    function automatic bit is_pow2(input int p);
        return (p > 0) && ((p & (p - 1)) == 0);
    endfunction

    // 1-based codeword position of data bit i (0-based)
    function automatic int data_pos(input int i);
        int cnt;
        cnt = -1;
        for (int p = 1; p < 256; p++) begin
            if (!is_pow2(p)) begin
                cnt++;
                if (cnt == i) return p;
            end
        end
        return 0;
    endfunction

endpackage

// File: rtl/hamm_encode.sv
module hamm_encode
    import hamm_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CHK_W  = 4,
    parameter int CODE_N = 12,
    parameter int DED    = 1,
    parameter int OUT_W  = CODE_N + DED
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [OUT_W-1:0]  code_o
);

    logic [CODE_N-1:0] base;
    logic              acc;

    always_comb begin
        base = '0;
        acc  = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            base[data_pos(i) - 1] = data_i[i];
        end
        // each check bit covers positions whose index has bit j set
        for (int j = 0; j < CHK_W; j++) begin
            acc = 1'b0;
            for (int p = 1; p <= CODE_N; p++) begin
                if (((p >> j) & 1) != 0) acc = acc ^ base[p - 1];
            end
            base[(1 << j) - 1] = acc;
        end
    end

    generate
        if (DED != 0) begin : g_ded
            assign code_o = {^base, base};
        end else begin : g_sec
            assign code_o = base;
        end
    endgenerate

endmodule

// File: rtl/hamm_check.sv
module hamm_check
    import hamm_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CHK_W  = 4,
    parameter int CODE_N = 12,
    parameter int DED    = 1,
    parameter int OUT_W  = CODE_N + DED
) (
    input  logic [OUT_W-1:0]  code_i,
    output logic [DATA_W-1:0] data_o,
    output logic [OUT_W-1:0]  code_o,
    output ecc_class_e        class_o
);

    logic [CHK_W-1:0] syn;
    logic [OUT_W-1:0] mask;
    logic             par_odd;

    generate
        if (DED != 0) begin : g_ded
            assign par_odd = ^code_i;
        end else begin : g_sec
            assign par_odd = 1'b0;
        end
    endgenerate

    always_comb begin
        syn = '0;
        for (int j = 0; j < CHK_W; j++) begin
            for (int p = 1; p <= CODE_N; p++) begin
                if (((p >> j) & 1) != 0) syn[j] = syn[j] ^ code_i[p - 1];
            end
        end

        mask    = '0;
        class_o = ECC_CLEAN;
        if (DED != 0) begin
            if (syn == '0) begin
                if (par_odd) begin
                    class_o         = ECC_FIXED;
                    mask[OUT_W - 1] = 1'b1;
                end
            end else if (par_odd && int'(syn) <= CODE_N) begin
                class_o             = ECC_FIXED;
                mask[int'(syn) - 1] = 1'b1;
            end else begin
                class_o = ECC_FATAL;
            end
        end else begin
            if (syn != '0) begin
                if (int'(syn) <= CODE_N) begin
                    class_o             = ECC_FIXED;
                    mask[int'(syn) - 1] = 1'b1;
                end else begin
                    class_o = ECC_FATAL;
                end
            end
        end

        code_o = code_i ^ mask;
        for (int i = 0; i < DATA_W; i++) begin
            data_o[i] = code_o[data_pos(i) - 1];
        end
    end

endmodule

// File: rtl/hamm_secded.sv
module hamm_secded
    import hamm_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int DED     = 1,
    parameter int REG_OUT = 1,
    localparam int CHK_W  = chk_bits(DATA_W),
    localparam int CODE_N = DATA_W + CHK_W,
    localparam int OUT_W  = CODE_N + DED
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [OUT_W-1:0]  wr_code_o,
    input  logic              rd_valid_i,
    input  logic [OUT_W-1:0]  rd_code_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [OUT_W-1:0]  fix_code_o,
    output logic              err_single_o,
    output logic              err_double_o,
    output logic              wb_req_o
);

    typedef struct packed {
        logic [OUT_W-1:0]  wcode;
        logic [DATA_W-1:0] rdata;
        logic [OUT_W-1:0]  fcode;
        logic              sgl;
        logic              dbl;
        logic              wb;
    } out_t;

    logic [OUT_W-1:0]  enc_code;
    logic [DATA_W-1:0] chk_data;
    logic [OUT_W-1:0]  chk_code;
    ecc_class_e        chk_class;
    out_t              out_d;
    out_t              out_q;

    hamm_encode #(
        .DATA_W(DATA_W), .CHK_W(CHK_W), .CODE_N(CODE_N), .DED(DED), .OUT_W(OUT_W)
    ) u_enc (
        .data_i(wr_data_i),
        .code_o(enc_code)
    );

    hamm_check #(
        .DATA_W(DATA_W), .CHK_W(CHK_W), .CODE_N(CODE_N), .DED(DED), .OUT_W(OUT_W)
    ) u_chk (
        .code_i (rd_code_i),
        .data_o (chk_data),
        .code_o (chk_code),
        .class_o(chk_class)
    );

    always_comb begin
        out_d       = '0;
        out_d.wcode = enc_code;
        out_d.rdata = chk_data;
        out_d.fcode = chk_code;
        out_d.sgl   = rd_valid_i && (chk_class == ECC_FIXED);
        out_d.dbl   = rd_valid_i && (chk_class == ECC_FATAL);
        out_d.wb    = rd_valid_i && (chk_class == ECC_FIXED);
    end

    generate
        if (REG_OUT != 0) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) out_q <= '0;
                else        out_q <= out_d;
            end
        end else begin : g_comb
            assign out_q = out_d;
        end
    endgenerate

    assign wr_code_o    = out_q.wcode;
    assign rd_data_o    = out_q.rdata;
    assign fix_code_o   = out_q.fcode;
    assign err_single_o = out_q.sgl;
    assign err_double_o = out_q.dbl;
    assign wb_req_o     = out_q.wb;

endmodule

// File: rtl/hamm_secded_chk.sv
module hamm_secded_chk #(
    parameter int DATA_W  = 8,
    parameter int CHK_W   = 4,
    parameter int CODE_N  = 12,
    parameter int DED     = 1,
    parameter int REG_OUT = 1,
    parameter int OUT_W   = CODE_N + DED
) (
    input logic              clk,
    input logic              rst_n,
    input logic [OUT_W-1:0]  wr_code_o,
    input logic              rd_valid_i,
    input logic [OUT_W-1:0]  fix_code_o,
    input logic              err_single_o,
    input logic              err_double_o,
    input logic              wb_req_o
);

    // nonzero when a codeword violates any parity equation
    function automatic logic [CHK_W:0] bad_word(input logic [OUT_W-1:0] c);
        logic [CHK_W:0] r;
        r = '0;
        for (int p = 1; p <= CODE_N; p++) begin
            for (int j = 0; j < CHK_W; j++) begin
                if (((p >> j) & 1) != 0) r[j] = r[j] ^ c[p - 1];
            end
        end
        if (DED != 0) r[CHK_W] = ^c;
        return r;
    endfunction

    // R1: every written codeword satisfies all check equations
    a_r1_wr_code_valid: assert property (@(posedge clk) disable iff (!rst_n)
        bad_word(wr_code_o) == '0);

    // R5: a corrected word offered for write-back is a valid codeword
    a_r5_fix_code_valid: assert property (@(posedge clk) disable iff (!rst_n)
        err_single_o |-> (bad_word(fix_code_o) == '0));

    // R5: write-back only accompanies a corrected single error
    a_r5_wb_needs_single: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req_o |-> err_single_o);

    // R6: single and uncorrectable never reported together
    a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_single_o && err_double_o));

    generate
        if (REG_OUT != 0) begin : g_lat
            // R9: no flag follows a cycle without a valid read
            a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
                !rd_valid_i |=> !(err_single_o || err_double_o || wb_req_o));
        end else begin : g_nolat
            a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
                !rd_valid_i |-> !(err_single_o || err_double_o || wb_req_o));
        end
    endgenerate

endmodule

bind hamm_secded hamm_secded_chk #(
    .DATA_W(DATA_W), .CHK_W(CHK_W), .CODE_N(CODE_N),
    .DED(DED), .REG_OUT(REG_OUT), .OUT_W(OUT_W)
) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_code_o   (wr_code_o),
    .rd_valid_i  (rd_valid_i),
    .fix_code_o  (fix_code_o),
    .err_single_o(err_single_o),
    .err_double_o(err_double_o),
    .wb_req_o    (wb_req_o)
);

// File: tb/tb_hamm_secded.sv
module tb_hamm_secded;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  wr_data_i = '0;
    logic [12:0] wr_code_o;
    logic        rd_valid_i = 1'b0;
    logic [12:0] rd_code_i = '0;
    logic [7:0]  rd_data_o;
    logic [12:0] fix_code_o;
    logic        err_single_o, err_double_o, wb_req_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    hamm_secded dut (
        .clk(clk), .rst_n(rst_n),
        .wr_data_i(wr_data_i), .wr_code_o(wr_code_o),
        .rd_valid_i(rd_valid_i), .rd_code_i(rd_code_i),
        .rd_data_o(rd_data_o), .fix_code_o(fix_code_o),
        .err_single_o(err_single_o), .err_double_o(err_double_o),
        .wb_req_o(wb_req_o)
    );

    typedef struct {
        logic [12:0] wcode;
        logic [7:0]  rdata;
        logic [12:0] fcode;
        logic        sgl, dbl, wb;
        string       tag;
    } exp_t;

    exp_t sb[$];

    // encoding built straight from the position equations (R1)
    function automatic logic [12:0] enc(input logic [7:0] d);
        logic e [1:13];
        logic [12:0] w;
        e[3] = d[0]; e[5] = d[1]; e[6] = d[2]; e[7] = d[3];
        e[9] = d[4]; e[10] = d[5]; e[11] = d[6]; e[12] = d[7];
        e[1] = e[3] ^ e[5] ^ e[7] ^ e[9] ^ e[11];
        e[2] = e[3] ^ e[6] ^ e[7] ^ e[10] ^ e[11];
        e[4] = e[5] ^ e[6] ^ e[7] ^ e[12];
        e[8] = e[9] ^ e[10] ^ e[11] ^ e[12];
        e[13] = 1'b0;
        for (int k = 1; k <= 12; k++) e[13] = e[13] ^ e[k];
        for (int k = 1; k <= 13; k++) w[k-1] = e[k];
        return w;
    endfunction

    function automatic logic [7:0] raw_data(input logic [12:0] w);
        return {w[11], w[10], w[9], w[8], w[6], w[5], w[4], w[2]};
    endfunction

    function automatic logic [12:0] pos(input int p);
        return 13'd1 << (p - 1);
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // kind: 0 clean, 1 correctable, 2 uncorrectable
    task automatic drive(input logic [7:0] wd, input logic [7:0] rd,
                         input logic [12:0] flip, input bit vld,
                         input int kind, input string tag);
        exp_t x;
        logic [12:0] code;
        @(negedge clk);
        code       = enc(rd) ^ flip;
        wr_data_i  = wd;
        rd_code_i  = code;
        rd_valid_i = vld;
        x.wcode = enc(wd);
        x.tag   = tag;
        if (kind == 1) begin
            x.rdata = rd;
            x.fcode = enc(rd);
        end else begin
            x.rdata = raw_data(code);
            x.fcode = code;
        end
        x.sgl = vld && (kind == 1);
        x.dbl = vld && (kind == 2);
        x.wb  = vld && (kind == 1);
        sb.push_back(x);
    endtask

    // monitor: one result per edge, one cycle after the stimulus (R10)
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t x;
                x = sb.pop_front();
                check(x.tag, "wr_code", 32'(wr_code_o), 32'(x.wcode));
                check(x.tag, "rd_data", 32'(rd_data_o), 32'(x.rdata));
                check(x.tag, "fix_code", 32'(fix_code_o), 32'(x.fcode));
                check(x.tag, "err_single", 32'(err_single_o), 32'(x.sgl));
                check(x.tag, "err_double", 32'(err_double_o), 32'(x.dbl));
                check(x.tag, "wb_req", 32'(wb_req_o), 32'(x.wb));
            end
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int dpos[8] = '{3, 5, 6, 7, 9, 10, 11, 12};
        int cpos[4] = '{1, 2, 4, 8};

        // R10: reset clears outputs even with active inputs
        wr_data_i  = 8'hFF;
        rd_code_i  = 13'h1FFF;
        rd_valid_i = 1'b1;
        repeat (3) @(negedge clk);
        check("R10", "reset wr_code", 32'(wr_code_o), 0);
        check("R10", "reset flags", 32'({err_single_o, err_double_o, wb_req_o}), 0);
        check("R10", "reset rd_data", 32'(rd_data_o), 0);
        rst_n = 1'b1;

        // R1 R2 R10: clean traffic, write and read together
        drive(8'hA5, 8'h3C, 13'h0, 1, 0, "R1_R2");
        drive(8'h00, 8'hFF, 13'h0, 1, 0, "R1_R2");
        drive(8'hFF, 8'h00, 13'h0, 1, 0, "R1_R2");
        drive(8'h5A, 8'h81, 13'h0, 1, 0, "R10");

        // R3 R5: each data position flipped
        foreach (dpos[i]) drive(8'(i * 37), 8'hC6, pos(dpos[i]), 1, 1, "R3_R5");

        // R4 R5: each check position flipped
        foreach (cpos[i]) drive(8'(8'h11 * i), 8'h39, pos(cpos[i]), 1, 1, "R4_R5");

        // R8: overall parity bit flipped
        drive(8'h77, 8'h6B, pos(13), 1, 1, "R8");
        drive(8'h12, 8'h00, pos(13), 1, 1, "R8");

        // R6: two flips
        drive(8'h34, 8'hE1, pos(3) | pos(5), 1, 2, "R6");
        drive(8'h56, 8'h2F, pos(1) | pos(12), 1, 2, "R6");
        drive(8'h78, 8'h90, pos(7) | pos(13), 1, 2, "R6");

        // R7: syndromes 13, 14, 15
        drive(8'h9A, 8'h4D, pos(1) | pos(4) | pos(8), 1, 2, "R7");
        drive(8'hBC, 8'h4D, pos(2) | pos(4) | pos(8), 1, 2, "R7");
        drive(8'hDE, 8'hB2, pos(1) | pos(2) | pos(4) | pos(8), 1, 2, "R7");

        // R9: read not valid, corrupted words raise nothing
        drive(8'h01, 8'h55, pos(6), 0, 1, "R9");
        drive(8'h02, 8'hAA, pos(3) | pos(9), 0, 2, "R9");
        drive(8'h03, 8'h0F, pos(1) | pos(4) | pos(8), 0, 2, "R9");
        drive(8'h04, 8'hF0, 13'h0, 1, 0, "R2");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule